// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port with two registers reached over a simple single-cycle memory-mapped bus. One register sets the direction of each pin. The other holds the output latch. The latch is not a plain word. It is seen at 256 aliased word addresses, and word-address bits [9:2] of every access act as a per-pin mask. A write changes only the pins whose mask bit is set. A read returns zero for every pin whose mask bit is clear.

Because of this, independent software agents can each own a subset of pins. Each agent updates its own pins with a single store, and no read-modify-write sequence is needed. The port drives an output enable and an output level to each pad. It samples each pad level through a two-flop synchronizer. On a read, each pin returns either the latch or the synchronized pad, depending on its direction.

Top module: `masked_gpio_port`

## Requirements
- R1: Any access whose byte address lies in 0x000..0x3FC targets the data latch. Address bits [9:2] form the mask, with bit 2+i gating pin i. The same latch therefore appears at all 256 word addresses of that range.
- R2: A write to the data range loads `bus_wdata[i]` into latch bit i only when mask bit i is 1 and pin i is an output. `pad_out` shows the new latch on the clock edge that accepts the write.
- R3: A data write leaves the latch bit of an input pin unchanged. If that pin is later turned into an output, it drives the value held before the ignored write.
- R4: A read presented with `bus_sel`=1 and `bus_wr`=0 returns its data on `bus_rdata` after the next clock edge. Pins whose mask bit is 0 read as 0, and bits [31:8] always read as 0.
- R5: In a data read, an output pin returns its latch bit and an input pin returns the synchronized pad level. A pad change applied before edge e is visible to a read presented after edge e+1.
- R6: The direction register sits at byte address 0x400, where 1 means output and 0 means input. `pad_oe[i]` equals direction bit i from the edge after the write. A read of 0x400 returns the direction bits in [7:0].
- R7: An active-low asynchronous reset clears the latch, the direction register and the read data. After reset, every pin is an input, `pad_oe`=0, `pad_out`=0 and `bus_rdata`=0.
- R8: Accesses to addresses outside the data range and 0x400 change no state, and their reads return 0.
- R9: `bus_rdata` keeps its value in every cycle that presents no read, including write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output level |

## Verification
A corrupted latch bit on an output pin shows on `pad_out` in the same cycle. On an input pin, the same fault stays hidden until that pin is made an output or read back, so the bench toggles directions after writes to expose it. A wrong direction bit shows at once on `pad_oe`. A mask or read-selection error shows on `bus_rdata` one edge after the read is presented. Synchronizer depth errors shift the first read that sees a pad change by one cycle. A reference model that runs on every clock catches that shift.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Kind of bus access after address decoding
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2,
        ACC_VOID = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          PIN_W   = 8,
    parameter logic [11:0] DIR_OFS = 12'h400
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [PIN_W-1:0]  mask
);
    localparam int MSK_LO = 2;
    localparam int MSK_HI = PIN_W + 1;

    logic in_data_range;
    logic is_dir;

    // Mask bits sit directly above the byte offset
    assign mask          = addr[MSK_HI:MSK_LO];
    assign in_data_range = (addr[ADDR_W-1:MSK_HI+1] == '0);
    assign is_dir        = (addr[ADDR_W-1:2] == DIR_OFS[ADDR_W-1:2]);

    always_comb begin
        if (!sel)               kind = ACC_IDLE;
        else if (in_data_range) kind = ACC_DATA;
        else if (is_dir)        kind = ACC_DIR;
        else                    kind = ACC_VOID;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PIN_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_raw,
    output logic [PIN_W-1:0] pin_sync
);
    logic [PIN_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= pin_raw;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
    import gpio_mask_pkg::*;
#(
    parameter int PIN_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic              wr,
    input  logic [PIN_W-1:0]  mask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [PIN_W-1:0]  latch_o,
    output logic [PIN_W-1:0]  dir_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [PIN_W-1:0]  latch;
        logic [PIN_W-1:0]  dir;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [PIN_W-1:0] wr_en;
    logic [PIN_W-1:0] pin_view;

    always_comb begin
        st_d     = st_q;
        wr_en    = mask & st_q.dir;
        pin_view = (st_q.dir & st_q.latch) | (~st_q.dir & pin_sync);
        unique case (kind)
            ACC_DATA: begin
                if (wr) begin
                    st_d.latch = (st_q.latch & ~wr_en) | (wdata[PIN_W-1:0] & wr_en);
                end else begin
                    st_d.rdata = DATA_W'(mask & pin_view);
                end
            end
            ACC_DIR: begin
                if (wr) st_d.dir   = wdata[PIN_W-1:0];
                else    st_d.rdata = DATA_W'(st_q.dir);
            end
            ACC_VOID: begin
                if (!wr) st_d.rdata = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.latch;
    assign dir_o   = st_q.dir;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
    import gpio_mask_pkg::*;
#(
    parameter int          PIN_W       = 8,
    parameter int          ADDR_W      = 12,
    parameter int          DATA_W      = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [11:0] DIR_OFS     = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out
);
    acc_kind_e        kind;
    logic [PIN_W-1:0] mask;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] latch;
    logic [PIN_W-1:0] dir;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .DIR_OFS(DIR_OFS)) u_dec (
        .sel  (bus_sel),
        .addr (bus_addr),
        .kind (kind),
        .mask (mask)
    );

    gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_port_core #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .wr       (bus_wr),
        .mask     (mask),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .latch_o  (latch),
        .dir_o    (dir),
        .rdata_o  (bus_rdata)
    );

    // One output enable per pin, taken from its direction bit
    for (genvar i = 0; i < PIN_W; i++) begin : g_pad
        assign pad_oe[i]  = dir[i];
        assign pad_out[i] = latch[i];
    end
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter int          PIN_W   = 8,
    parameter int          ADDR_W  = 12,
    parameter int          DATA_W  = 32,
    parameter logic [11:0] DIR_OFS = 12'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PIN_W-1:0]  pad_oe,
    input logic [PIN_W-1:0]  pad_out
);
    logic             c_data;
    logic             c_dir;
    logic [PIN_W-1:0] c_mask;

    assign c_data = bus_sel && (bus_addr[ADDR_W-1:PIN_W+2] == '0);
    assign c_dir  = bus_sel && (bus_addr[ADDR_W-1:2] == DIR_OFS[ADDR_W-1:2]);
    assign c_mask = bus_addr[PIN_W+1:2];

    // R2: unmasked pins keep their level across a data write
    p_unmasked_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_data && bus_wr) |=> (((pad_out ^ $past(pad_out)) & ~$past(c_mask)) == '0));

    // R3: latch bits of input pins never change
    p_input_latch_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

    // R4: masked-off pins and upper bits read as zero
    p_read_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_data && !bus_wr) |=> ((bus_rdata & ~DATA_W'($past(c_mask))) == '0));

    // R6: direction write reaches the output enables
    p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dir && bus_wr) |=> (pad_oe == $past(bus_wdata[PIN_W-1:0])));

    // R6: output enables move only on a direction write
    p_oe_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_dir && bus_wr) |=> $stable(pad_oe));

    // R8: reads outside both registers return zero
    p_void_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !c_data && !c_dir) |=> (bus_rdata == '0));

    // R9: read data held when no read is presented
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

    // R7: outputs are clear while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r7: assert (pad_oe == '0 && pad_out == '0 && bus_rdata == '0);
        end
    end
endmodule

bind masked_gpio_port gpio_port_checker #(
    .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_OFS(DIR_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_masked_gpio_port.sv
`timescale 1ns/1ps
module sim_masked_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    run_cmp = 1'b0;
    bit    done = 1'b0;
    string ph = "R5";

    always #2.5 clk = ~clk;

    masked_gpio_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // Behavioural reference, updated on each rising edge
    logic [7:0]  m_lat, m_dir, m_seen1, m_seen2;
    logic [31:0] m_rd;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_dir = 0; m_rd = 0; m_seen1 = 0; m_seen2 = 0;
        end else begin
            if (bus_sel) begin
                logic [7:0] msk;
                msk = bus_addr[9:2];
                if (bus_addr[11:10] == 2'b00) begin
                    if (bus_wr) m_lat = (m_lat & ~(msk & m_dir)) | (bus_wdata[7:0] & msk & m_dir);
                    else        m_rd  = {24'd0, msk & ((m_dir & m_lat) | (~m_dir & m_seen2))};
                end else if (bus_addr[11:2] == 10'h100) begin
                    if (bus_wr) m_dir = bus_wdata[7:0];
                    else        m_rd  = {24'd0, m_dir};
                end else if (!bus_wr) begin
                    m_rd = 0;
                end
            end
            m_seen2 = m_seen1;
            m_seen1 = pad_in;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("R6", "pad_oe", {24'd0, pad_oe}, {24'd0, m_dir});
            chk("R2", "pad_out", {24'd0, pad_out}, {24'd0, m_lat});
            chk(ph, "bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(logic [11:0] a);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        idle(3);
        // R7: reset state
        chk("R7", "oe after reset", {24'd0, pad_oe}, 0);
        chk("R7", "out after reset", {24'd0, pad_out}, 0);
        chk("R7", "rdata after reset", bus_rdata, 0);
        rst_n = 1;
        idle(1);
        run_cmp = 1;

        // R6: direction write and read back
        ph = "R6";
        wr(12'h400, 32'h0000_000F);
        chk("R6", "oe after dir write", {24'd0, pad_oe}, 32'h0F);
        rd(12'h400);
        chk("R6", "dir read", bus_rdata, 32'h0F);

        // R2: full-mask write, only output pins take it
        ph = "R2";
        wr(12'h3FC, 32'hFFFF_FFA5);
        chk("R2", "full mask write", {24'd0, pad_out}, 32'h05);

        // R1: alias with mask 0x03 sets only pins 1:0
        ph = "R1";
        wr(12'h00C, 32'hFF);
        chk("R1", "mask 0x03 write", {24'd0, pad_out}, 32'h07);
        wr(12'h000, 32'h00);
        chk("R1", "mask 0 write", {24'd0, pad_out}, 32'h07);

        // R3: earlier write to input pins was dropped
        ph = "R3";
        wr(12'h400, 32'hFF);
        chk("R3", "inputs kept latch", {24'd0, pad_out}, 32'h07);
        wr(12'h400, 32'h0F);

        // R4/R5: mixed read-back and masking
        ph = "R5";
        pad_in = 8'h3C;
        idle(3);
        rd(12'h3FC);
        chk("R5", "mixed read", bus_rdata, 32'h37);
        ph = "R4";
        rd(12'h0C0);
        chk("R4", "mask 0x30 read", bus_rdata, 32'h30);
        rd(12'h000);
        chk("R4", "mask 0 read", bus_rdata, 32'h00);

        // R5: synchronizer latency, back-to-back reads after a pad change
        ph = "R5";
        @(negedge clk); pad_in = 8'hC0; bus_sel = 1; bus_wr = 0; bus_addr = 12'h3FC;
        idle(3);
        bus_sel = 0;
        idle(1);
        chk("R5", "new pad level read", bus_rdata, 32'hC7);

        // R8: unmapped accesses
        ph = "R8";
        wr(12'h800, 32'hFF);
        wr(12'h404, 32'hFF);
        chk("R8", "oe untouched", {24'd0, pad_oe}, 32'h0F);
        chk("R8", "out untouched", {24'd0, pad_out}, 32'h07);
        rd(12'h800);
        chk("R8", "void read", bus_rdata, 0);

        // R9: read data held across idle and write cycles
        ph = "R9";
        rd(12'h400);
        wr(12'h3FC, 32'h00);
        idle(4);
        chk("R9", "rdata held", bus_rdata, 32'h0F);

        // Random traffic against the model
        ph = "R5";
        for (int k = 0; k < 3000; k++) begin
            int sel_kind;
            @(negedge clk);
            sel_kind  = int'($urandom_range(0, 9));
            bus_sel   = ($urandom_range(0, 3) != 0);
            bus_wr    = $urandom_range(0, 1) == 1;
            bus_wdata = $urandom;
            if (sel_kind < 7)       bus_addr = {2'b00, 8'($urandom), 2'b00};
            else if (sel_kind < 9)  bus_addr = 12'h400;
            else                    bus_addr = 12'($urandom) | 12'h800;
            if ($urandom_range(0, 7) == 0) pad_in = 8'($urandom);
        end
        @(negedge clk); bus_sel = 0;

        // R7: reset in mid-run
        run_cmp = 0;
        @(negedge clk); rst_n = 0;
        idle(2);
        chk("R7", "oe mid-run reset", {24'd0, pad_oe}, 0);
        chk("R7", "out mid-run reset", {24'd0, pad_out}, 0);
        chk("R7", "rdata mid-run reset", bus_rdata, 0);
        rst_n = 1;
        idle(2);
        done = 1;
        finish_run();
    end
endmodule